// File: doc/BRIEF.md
# Idle-Driven Gating Mode Selector

This block watches the idle indication of one functional unit and decides how far to power that unit down. It counts consecutive idle cycles and compares the count with three programmable break-even thresholds. Passing the first threshold selects clock gating. Passing the second selects partial power gating, which switches off half of the switch groups and so wakes up quickly. Passing the third selects full power gating. Each deeper step is announced to a downstream shutdown sequencer with a one-cycle sleep request. Any activity drops the mode straight back to active and raises a one-cycle wake request.

The full-gating threshold adapts to how long idle periods turn out to be. If a period ends shortly after full gating was entered, the threshold doubles, up to a ceiling, because the shutdown probably cost more than it saved. If a period runs far past the threshold, the threshold halves, down to a floor, so that deep savings start sooner next time. The counting uses plain counters. No predictor is involved.

The design has four states: ACTIVE (code 00), CLOCK (01), PARTIAL (10) and FULL (11). These are the transitions:
- ACTIVE to CLOCK when the idle count reaches the clock threshold.
- CLOCK to PARTIAL when it reaches the partial threshold.
- PARTIAL to FULL when it reaches the full threshold.
- CLOCK, PARTIAL or FULL back to ACTIVE on any cycle in which the unit is not idle.

Top module: `idle_gate_sel`

## Requirements
- R1: After reset the mode is 00, both request pulses are low, and the thresholds hold their parameter defaults (clock 4, partial 16, full 64).
- R2: The mode output is coded 00 active, 01 clock-gated, 10 partial, 11 full. If the unit has been sampled idle on N consecutive rising edges, the mode becomes 01 at the edge where N equals the clock threshold. An idle period shorter than that threshold leaves the mode at 00.
- R3: While idle continues, the mode becomes 10 at the edge where N equals the partial threshold and 11 where N equals the full threshold. The mode never steps down, and never rises by more than one level per edge, while idle lasts.
- R4: At the first edge that samples the unit not idle, the mode becomes 00. For that one cycle the wake request is high, but only if the mode was not 00 before. The idle count restarts from zero for the next period.
- R5: The sleep request is high for exactly the cycle in which the mode has just stepped to a deeper level, and low at all other times.
- R6: A write with select 00 sets the clock threshold, 01 the partial threshold and 10 the full threshold. Select 11 is ignored. A write whose new value would break 0 < clock < partial < full is ignored.
- R7: When an idle period ends in full gating with an idle count below full threshold + 16, the full threshold doubles. It saturates at 16384.
- R8: When an idle period ends in full gating with an idle count above four times the full threshold, the full threshold halves. It never goes below the larger of 8 and partial threshold + 1.
- R9: The idle counter saturates at 65535 and does not wrap. The adaptation after a longer period therefore uses 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Watched unit is idle this cycle |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_sel_i | input | 2 | Threshold select: 00 clock, 01 partial, 10 full, 11 none |
| cfg_data_i | input | 16 | New threshold value in cycles |
| mode_o | output | 2 | Current gating mode code |
| sleep_req_o | output | 1 | One-cycle pulse on each deeper mode step |
| wake_req_o | output | 1 | One-cycle pulse when activity leaves a gated mode |

## Verification
The bench sweeps idle periods of many lengths against a running arithmetic model of the three thresholds. It checks the mode and both pulses on every cycle, so a threshold off by one shows up as a step one cycle early or late. Writes that break the ordering are followed by idle periods that would expose the changed timing if a write had been accepted.

The adaptive threshold is driven through several cases:
- repeated doubling, including saturation at the ceiling;
- halving that is clamped by the floor;
- halving that is clamped by partial threshold + 1.

The final case is an idle period a little longer than the counter range. A counter that wrapped would see a short period and double the threshold instead of halving it.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

    typedef enum logic [1:0] {
        GM_ACTIVE  = 2'b00,
        GM_CLOCK   = 2'b01,
        GM_PARTIAL = 2'b10,
        GM_FULL    = 2'b11
    } gmode_t;

    localparam logic [1:0] SEL_CLOCK   = 2'b00;
    localparam logic [1:0] SEL_PARTIAL = 2'b01;
    localparam logic [1:0] SEL_FULL    = 2'b10;

endpackage

// File: rtl/gsel_idle_ctr.sv
module gsel_idle_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_inc_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    assign cnt_inc_o = (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (idle_i) cnt_o <= cnt_inc_o;
        else             cnt_o <= '0;
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_o) == CNT_MAX && $past(idle_i)) |-> (cnt_o == CNT_MAX));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(idle_i) |-> (cnt_o == '0));

endmodule

// File: rtl/gsel_thresholds.sv
module gsel_thresholds #(
    parameter int CW        = 16,
    parameter int CG_INIT   = 4,
    parameter int PART_INIT = 16,
    parameter int FULL_INIT = 64,
    parameter int FULL_MAX  = 16384,
    parameter int FULL_MIN  = 8,
    parameter int WIN       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [CW-1:0] cfg_data_i,
    input  logic          end_full_i,
    input  logic [CW-1:0] end_cnt_i,
    output logic [CW-1:0] thr_cg_o,
    output logic [CW-1:0] thr_p_o,
    output logic [CW-1:0] thr_f_o
);
    import gsel_pkg::*;

    localparam int XW = CW + 2;

    logic [CW-1:0] cg_n, p_n, f_n;
    logic [XW-1:0] f_w, p_w, e_w, dbl_w, half_w, floor_w, shrink_w;
    logic          short_run, long_run;

    always_comb begin
        f_w      = {2'b00, thr_f_o};
        p_w      = {2'b00, thr_p_o};
        e_w      = {2'b00, end_cnt_i};
        short_run = e_w < (f_w + XW'(WIN));
        long_run  = e_w > (f_w << 2);
        dbl_w    = ((f_w << 1) > XW'(FULL_MAX)) ? XW'(FULL_MAX) : (f_w << 1);
        half_w   = f_w >> 1;
        floor_w  = (XW'(FULL_MIN) > (p_w + 1'b1)) ? XW'(FULL_MIN) : (p_w + 1'b1);
        shrink_w = (half_w > floor_w) ? half_w : floor_w;
    end

    always_comb begin
        cg_n = thr_cg_o;
        p_n  = thr_p_o;
        f_n  = thr_f_o;
        if (cfg_we_i) begin
            unique case (cfg_sel_i)
                SEL_CLOCK:   if (cfg_data_i != '0 && cfg_data_i < thr_p_o) cg_n = cfg_data_i;
                SEL_PARTIAL: if (cfg_data_i > thr_cg_o && cfg_data_i < thr_f_o) p_n = cfg_data_i;
                SEL_FULL:    if (cfg_data_i > thr_p_o) f_n = cfg_data_i;
                default:     ;
            endcase
        end else if (end_full_i) begin
            if (short_run)     f_n = dbl_w[CW-1:0];
            else if (long_run) f_n = shrink_w[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_cg_o <= CW'(CG_INIT);
            thr_p_o  <= CW'(PART_INIT);
            thr_f_o  <= CW'(FULL_INIT);
        end else begin
            thr_cg_o <= cg_n;
            thr_p_o  <= p_n;
            thr_f_o  <= f_n;
        end
    end

    // R6
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_cg_o != '0) && (thr_cg_o < thr_p_o) && (thr_p_o < thr_f_o));

    // R7
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_full_i && !cfg_we_i && short_run) |=> (thr_f_o >= $past(thr_f_o)));

    // R8
    shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (end_full_i && !cfg_we_i && long_run) |=> (thr_f_o <= $past(thr_f_o)));

endmodule

// File: rtl/gsel_mode_fsm.sv
module gsel_mode_fsm #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_i,
    input  logic [CW-1:0]   cnt_inc_i,
    input  logic [CW-1:0]   thr_cg_i,
    input  logic [CW-1:0]   thr_p_i,
    input  logic [CW-1:0]   thr_f_i,
    output gsel_pkg::gmode_t mode_o,
    output logic            sleep_req_o,
    output logic            wake_req_o,
    output logic            end_full_o
);
    import gsel_pkg::*;

    gmode_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            GM_ACTIVE:  if (idle_i && cnt_inc_i >= thr_cg_i) state_n = GM_CLOCK;
            GM_CLOCK:   if (!idle_i) state_n = GM_ACTIVE;
                        else if (cnt_inc_i >= thr_p_i) state_n = GM_PARTIAL;
            GM_PARTIAL: if (!idle_i) state_n = GM_ACTIVE;
                        else if (cnt_inc_i >= thr_f_i) state_n = GM_FULL;
            GM_FULL:    if (!idle_i) state_n = GM_ACTIVE;
            default:    state_n = GM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GM_ACTIVE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_req_o <= 1'b0;
            wake_req_o  <= 1'b0;
        end else begin
            sleep_req_o <= (state_n != GM_ACTIVE) && (state_n != state);
            wake_req_o  <= (state != GM_ACTIVE) && !idle_i;
        end
    end

    assign mode_o     = state;
    assign end_full_o = (state == GM_FULL) && !idle_i;

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (state == GM_ACTIVE || state == gmode_t'($past(state) + 2'd1)));

    // R4
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (state == GM_ACTIVE && $past(state) != GM_ACTIVE));

    // R5
    sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_o |-> (state != GM_ACTIVE && state != $past(state)));

    // R5
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sleep_req_o, wake_req_o}) <= 1);

endmodule

// File: rtl/idle_gate_sel.sv
module idle_gate_sel #(
    parameter int CW        = 16,
    parameter int CG_INIT   = 4,
    parameter int PART_INIT = 16,
    parameter int FULL_INIT = 64,
    parameter int FULL_MAX  = 16384,
    parameter int FULL_MIN  = 8,
    parameter int WIN       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [CW-1:0] cfg_data_i,
    output logic [1:0]    mode_o,
    output logic          sleep_req_o,
    output logic          wake_req_o
);
    import gsel_pkg::*;

    logic [CW-1:0] cnt, cnt_inc, thr_cg, thr_p, thr_f;
    logic          end_full;
    gmode_t        mode;

    gsel_idle_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i),
        .cnt_o(cnt), .cnt_inc_o(cnt_inc)
    );

    gsel_thresholds #(
        .CW(CW), .CG_INIT(CG_INIT), .PART_INIT(PART_INIT), .FULL_INIT(FULL_INIT),
        .FULL_MAX(FULL_MAX), .FULL_MIN(FULL_MIN), .WIN(WIN)
    ) u_thr (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
        .end_full_i(end_full), .end_cnt_i(cnt),
        .thr_cg_o(thr_cg), .thr_p_o(thr_p), .thr_f_o(thr_f)
    );

    gsel_mode_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .cnt_inc_i(cnt_inc),
        .thr_cg_i(thr_cg), .thr_p_i(thr_p), .thr_f_i(thr_f),
        .mode_o(mode), .sleep_req_o(sleep_req_o), .wake_req_o(wake_req_o),
        .end_full_o(end_full)
    );

    assign mode_o = mode;

endmodule

// File: tb/idle_gate_sel_test.sv
module idle_gate_sel_test;

    localparam int FMAX = 16384;
    localparam int FMIN = 8;
    localparam int WIN  = 16;
    localparam int CMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [15:0] data = '0;
    logic [1:0]  mode;
    logic        sleep_req, wake_req;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int m_cg = 4, m_p = 16, m_f = 64;

    always #10 clk = ~clk;

    idle_gate_sel uut (
        .clk(clk), .rst_n(rst_n), .idle_i(idle),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
        .mode_o(mode), .sleep_req_o(sleep_req), .wake_req_o(wake_req)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input int d);
        @(negedge clk);
        we = 1'b1; sel = s; data = 16'(d);
        @(negedge clk);
        we = 1'b0;
        if (s == 2'b00 && d != 0 && d < m_p) m_cg = d;
        else if (s == 2'b01 && d > m_cg && d < m_f) m_p = d;
        else if (s == 2'b10 && d > m_p) m_f = d;
    endtask

    task automatic run_period(input int len, input string req);
        bit bad = 1'b0;
        int got = 0, want = 0;
        int c, lo;
        @(negedge clk);
        idle = 1'b1;
        for (int i = 1; i <= len; i++) begin
            int em;
            @(posedge clk); #2;
            em = (i >= m_f) ? 3 : (i >= m_p) ? 2 : (i >= m_cg) ? 1 : 0;
            if (!bad && (mode !== 2'(em) ||
                         sleep_req !== (i == m_cg || i == m_p || i == m_f) ||
                         wake_req !== 1'b0)) begin
                bad = 1'b1;
                got = {mode, sleep_req, wake_req};
                want = (em << 2) | (((i == m_cg || i == m_p || i == m_f) ? 1 : 0) << 1);
            end
        end
        check({req, " mode/sleep during idle"}, !bad, got, want);
        @(negedge clk);
        idle = 1'b0;
        @(posedge clk); #2;
        check("R4 mode back to 00", mode === 2'b00, int'(mode), 0);
        check("R4 wake pulse", wake_req === (len >= m_cg), int'(wake_req), (len >= m_cg) ? 1 : 0);
        @(posedge clk); #2;
        check("R4 wake one cycle", wake_req === 1'b0 && sleep_req === 1'b0, int'(wake_req), 0);
        c = (len > CMAX) ? CMAX : len;
        if (len >= m_f) begin
            if (c < m_f + WIN) m_f = (2 * m_f > FMAX) ? FMAX : 2 * m_f;
            else if (c > 4 * m_f) begin
                lo = (FMIN > m_p + 1) ? FMIN : m_p + 1;
                m_f = (m_f / 2 > lo) ? m_f / 2 : lo;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 200000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R1 reset state
        check("R1 reset mode", mode === 2'b00, int'(mode), 0);
        check("R1 reset pulses", sleep_req === 1'b0 && wake_req === 1'b0, int'(sleep_req), 0);

        // R2 / R3 default thresholds
        run_period(3, "R2 short");
        run_period(10, "R2 clock");
        run_period(30, "R3 partial");
        run_period(100, "R3 full");

        // R6 valid and invalid writes
        wr(2'b00, 2);
        wr(2'b01, 5);
        wr(2'b10, 9);
        wr(2'b00, 5);
        wr(2'b00, 0);
        wr(2'b10, 5);
        wr(2'b01, 9);
        wr(2'b11, 1);
        // R7 doubling twice, then R8 halving
        run_period(12, "R7 grow");
        run_period(20, "R7 grow again");
        run_period(200, "R8 shrink");
        run_period(100, "R8 shrink");
        run_period(50, "R8 floor min");
        run_period(40, "R8 floor held");
        wr(2'b10, 13);
        wr(2'b01, 12);
        run_period(60, "R8 floor partial");
        run_period(20, "R6 check");
        // R7 saturation at ceiling
        wr(2'b10, 16000);
        run_period(16005, "R7 ceiling");
        run_period(30, "R7 after ceiling");
        // R9 counter saturation
        wr(2'b10, 64);
        wr(2'b01, 16);
        wr(2'b00, 4);
        run_period(65560, "R9 saturate");
        run_period(40, "R9 halved");
        run_period(80, "R7 regrown");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule